// File: doc/BRIEF.md
# Stream Cipher Initialization Sequencer

This block steers the setup of a stream cipher whose state lives in two registers, R and S, held in a separate update core. A single-cycle start pulse captures an 80-bit key, an initialization vector (IV) and the IV length. The block then takes the core through a fixed sequence. First it clears both registers to zero. Next it absorbs the IV bits one at a time, then the key bits one at a time, and then it runs a counted stretch of warm-up rounds. After that it hands over to keystream mode. Key and IV material never reaches the state in parallel. Every bit is the input bit of its own update step, and each step is requested one per cycle.

The block exposes the step interface only. `clear_o` asks the core to zero R and S. `step_o` asks for one update. `bit_o` is the bit to absorb in that update. `mix_o` selects the initialization-style update, as opposed to the plain keystream update. The nonlinear update itself is not part of this block.

The state machine has six states. ST_IDLE follows reset. ST_CLEAR lasts one cycle. ST_IV absorbs the IV, ST_KEY absorbs the key, ST_PRE runs the warm-up rounds and ST_RUN is keystream mode. Its transitions are as follows:
- start moves any state to ST_CLEAR.
- ST_CLEAR moves to ST_IV, or to ST_KEY when the IV length is zero.
- ST_IV moves to ST_KEY after the last IV bit.
- ST_KEY moves to ST_PRE after the 80th key bit.
- ST_PRE moves to ST_RUN after the 100th warm-up round.
- ST_RUN stays put until the next start.

Top module: `ksi_seq`

## Requirements
- R1: A start pulse sampled at a clock edge makes the next cycle a clear cycle. In that cycle `clear_o` is 1 and `step_o`, `mix_o`, `bit_o` and `ready_o` are all 0. `clear_o` is 0 in every other cycle.
- R2: With IV length L (1 to 80), the L cycles after the clear cycle each have `step_o`=1 and `mix_o`=1. `bit_o` carries `iv_i[L-1]`, then `iv_i[L-2]`, and so on down to `iv_i[0]`. The values used are the ones captured when start was sampled.
- R3: An IV length of 0 skips the IV cycles, so key absorption starts right after the clear cycle. A length above 80 is treated as 80.
- R4: The next 80 cycles each have `step_o`=1 and `mix_o`=1. `bit_o` carries `key_i[79]` first and `key_i[0]` last, using the key captured at start.
- R5: The next 100 cycles are warm-up rounds, each with `step_o`=1, `mix_o`=1 and `bit_o`=0. They are counted by a 7-bit counter.
- R6: In the first cycle after the warm-up rounds, `ready_o` rises. From then on, every cycle has `ready_o`=1, `step_o`=1, `mix_o`=0 and `bit_o`=0, until a start pulse is sampled.
- R7: A start pulse restarts the sequence from the clear cycle in any state. This includes ST_RUN and the last warm-up cycle, and start takes priority over every other transition.
- R8: While reset is asserted, and after it until the first start, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle pulse that captures the inputs and begins a new sequence |
| key_i | input | 80 | Key, absorbed most significant bit first |
| iv_i | input | 80 | IV; the low L bits are used |
| iv_len_i | input | 7 | IV length L; values above 80 are treated as 80 |
| clear_o | output | 1 | Request to zero both state registers |
| step_o | output | 1 | Request for one state update this cycle |
| bit_o | output | 1 | Bit to absorb in this update |
| mix_o | output | 1 | 1 = initialization update, 0 = keystream update |
| ready_o | output | 1 | High in keystream mode |

## Verification
Two functions can fall in the same cycle: the end of the warm-up run and a restart. The bench raises start during the 100th warm-up round. At that edge the ST_PRE to ST_RUN move and the move back to ST_CLEAR compete. The bench then requires the next cycle to be a clear cycle with `ready_o` low, and it checks the whole fresh sequence that follows. A restart during ST_RUN and a restart in the middle of key absorption are judged the same way.

// File: rtl/ksi_pkg.sv
package ksi_pkg;

    localparam int KSI_KEY_BITS   = 80;
    localparam int KSI_IV_MAX     = 80;
    localparam int KSI_PRE_ROUNDS = 100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_IV,
        ST_KEY,
        ST_PRE,
        ST_RUN
    } ksi_state_e;

endpackage

// File: rtl/ksi_shreg.sv
// Left-shifting bit source: parallel load, then one bit per shift, MSB first.
module ksi_shreg #(
    parameter int W = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         msb_o
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= data_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb_o = sh_q[W-1];

endmodule

// File: rtl/ksi_downcnt.sv
// Loadable down counter; last_o flags the final counted cycle.
module ksi_downcnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/ksi_fsm.sv
module ksi_fsm
    import ksi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       iv_none_i,
    input  logic       data_last_i,
    input  logic       pre_last_i,
    output ksi_state_e state_o
);

    ksi_state_e st_q;
    ksi_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d = ST_CLEAR;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_CLEAR: st_d = iv_none_i ? ST_KEY : ST_IV;
                ST_IV:    if (data_last_i) st_d = ST_KEY;
                ST_KEY:   if (data_last_i) st_d = ST_PRE;
                ST_PRE:   if (pre_last_i)  st_d = ST_RUN;
                ST_RUN:   st_d = ST_RUN;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/ksi_seq.sv
module ksi_seq
    import ksi_pkg::*;
#(
    parameter int KEY_W  = KSI_KEY_BITS,
    parameter int IV_W   = KSI_IV_MAX,
    parameter int PRE_N  = KSI_PRE_ROUNDS,
    parameter int LEN_W  = $clog2(IV_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [IV_W-1:0]  iv_i,
    input  logic [LEN_W-1:0] iv_len_i,
    output logic             clear_o,
    output logic             step_o,
    output logic             bit_o,
    output logic             mix_o,
    output logic             ready_o
);

    localparam int DMAX   = (KEY_W > IV_W) ? KEY_W : IV_W;
    localparam int DCNT_W = $clog2(DMAX + 1);
    localparam int PCNT_W = $clog2(PRE_N + 1);

    ksi_state_e      state;
    logic [LEN_W-1:0] len_eff;
    logic [IV_W-1:0]  iv_aligned;
    logic             iv_none_q;
    logic             iv_msb;
    logic             key_msb;
    logic             data_last;
    logic             pre_last;
    logic             dcnt_load;
    logic [DCNT_W-1:0] dcnt_val;
    logic             pcnt_load;

    // Clamp the IV length and left-align the used bits so they leave MSB first.
    assign len_eff    = (iv_len_i > LEN_W'(IV_W)) ? LEN_W'(IV_W) : iv_len_i;
    assign iv_aligned = iv_i << (LEN_W'(IV_W) - len_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iv_none_q <= 1'b0;
        end else if (start_i) begin
            iv_none_q <= (len_eff == '0);
        end
    end

    ksi_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .iv_none_i   (iv_none_q),
        .data_last_i (data_last),
        .pre_last_i  (pre_last),
        .state_o     (state)
    );

    ksi_shreg #(.W(IV_W)) u_iv_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .data_i  (iv_aligned),
        .shift_i (state == ST_IV),
        .msb_o   (iv_msb)
    );

    ksi_shreg #(.W(KEY_W)) u_key_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .data_i  (key_i),
        .shift_i (state == ST_KEY),
        .msb_o   (key_msb)
    );

    // Data counter: IV length at start, key width on entry to key absorption.
    always_comb begin
        dcnt_load = 1'b0;
        dcnt_val  = DCNT_W'(KEY_W);
        if (start_i) begin
            dcnt_load = 1'b1;
            dcnt_val  = DCNT_W'(len_eff);
        end else if ((state == ST_CLEAR && iv_none_q) ||
                     (state == ST_IV && data_last)) begin
            dcnt_load = 1'b1;
        end
    end

    ksi_downcnt #(.W(DCNT_W)) u_dcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (dcnt_load),
        .val_i  (dcnt_val),
        .dec_i  ((state == ST_IV) || (state == ST_KEY)),
        .last_o (data_last)
    );

    assign pcnt_load = !start_i && (state == ST_KEY) && data_last;

    ksi_downcnt #(.W(PCNT_W)) u_pcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (pcnt_load),
        .val_i  (PCNT_W'(PRE_N)),
        .dec_i  (state == ST_PRE),
        .last_o (pre_last)
    );

    // Output decode from the state alone.
    always_comb begin
        clear_o = 1'b0;
        step_o  = 1'b0;
        bit_o   = 1'b0;
        mix_o   = 1'b0;
        ready_o = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_CLEAR: clear_o = 1'b1;
            ST_IV: begin
                step_o = 1'b1;
                mix_o  = 1'b1;
                bit_o  = iv_msb;
            end
            ST_KEY: begin
                step_o = 1'b1;
                mix_o  = 1'b1;
                bit_o  = key_msb;
            end
            ST_PRE: begin
                step_o = 1'b1;
                mix_o  = 1'b1;
            end
            ST_RUN: begin
                step_o  = 1'b1;
                ready_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ksi_seq_chk.sv
module ksi_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic clear_o,
    input logic step_o,
    input logic bit_o,
    input logic mix_o,
    input logic ready_o
);

    // R1: a clear cycle issues no step and is never a keystream cycle
    a_r1_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> (!step_o && !ready_o && !mix_o && !bit_o));

    // R2: the mixing flag only accompanies a step request
    a_r2_mix_with_step: assert property (@(posedge clk) disable iff (!rst_n)
        mix_o |-> step_o);

    // R5: keystream mode is only entered straight from mixing steps
    a_r5_pre_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(step_o && mix_o && !bit_o));

    // R6: keystream cycles step with no mixing and no input bit
    a_r6_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (step_o && !mix_o && !bit_o));

    // R6: ready holds while no start arrives
    a_r6_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start_i) |=> ready_o);

    // R7: start always leads to a clear cycle
    a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> clear_o);

    // R8: all outputs quiet while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r8_reset_quiet: assert (!clear_o && !step_o && !bit_o && !mix_o && !ready_o);
        end
    end

endmodule

bind ksi_seq ksi_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .clear_o (clear_o),
    .step_o  (step_o),
    .bit_o   (bit_o),
    .mix_o   (mix_o),
    .ready_o (ready_o)
);

// File: tb/sim_ksi_seq.sv
`timescale 1ns/1ps
module sim_ksi_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [79:0] key_i = '0;
    logic [79:0] iv_i = '0;
    logic [6:0]  iv_len_i = '0;
    logic        clear_o, step_o, bit_o, mix_o, ready_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ksi_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .iv_i(iv_i), .iv_len_i(iv_len_i), .clear_o(clear_o), .step_o(step_o),
        .bit_o(bit_o), .mix_o(mix_o), .ready_o(ready_o)
    );

    // {key, iv, len}
    localparam logic [166:0] VEC [4] = '{
        {80'h0123_4567_89AB_CDEF_0F1E, 80'hFEDC_BA98_7654_3210_E1D2, 7'd80},
        {80'hFFFF_0000_FFFF_0000_AAAA, 80'h0000_0000_0000_0000_002D, 7'd6},
        {80'h8000_0000_0000_0000_0001, 80'hFEDC_BA98_7654_3210_E1D2, 7'd0},
        {80'h5A5A_5A5A_5A5A_5A5A_5A5A, 80'h0000_0000_0000_0000_0001, 7'd1}
    };

    task automatic check5(input string tag, input int n, input logic [4:0] exp);
        logic [4:0] act;
        act = {clear_o, step_o, bit_o, mix_o, ready_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d {clr,stp,bit,mix,rdy} actual %b expected %b",
                     tag, n, act, exp);
        end
    endtask

    // Pulse start, then check ncyc cycles counted from the clear cycle (n=0).
    task automatic run_seq(input logic [79:0] k, input logic [79:0] v,
                           input logic [6:0] len, input int ncyc, input string tag0);
        int leff;
        leff = (len > 7'd80) ? 80 : int'(len);
        @(negedge clk);
        key_i = k; iv_i = v; iv_len_i = len; start_i = 1'b1;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (n == 0)
                check5(tag0, n, 5'b10000);
            else if (n <= leff)
                check5((len > 7'd80) ? "R3/R2 iv" : "R2 iv", n, {2'b01, v[leff-n], 2'b10});
            else if (n <= leff + 80)
                check5((leff == 0 || len > 7'd80) ? "R3/R4 key" : "R4 key", n,
                       {2'b01, k[79-(n-leff-1)], 2'b10});
            else if (n <= leff + 180)
                check5("R5 preclock", n, 5'b01010);
            else
                check5("R6 keystream", n, 5'b01001);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check5("R8 in reset", 0, 5'b00000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check5("R8 idle after reset", 0, 5'b00000);

        // Table walk: full sequences with ready held for 20 cycles
        for (int i = 0; i < 4; i++) begin
            run_seq(VEC[i][166:87], VEC[i][86:7], VEC[i][6:0],
                    int'(VEC[i][6:0]) + 201, "R1 clear");
        end

        // R3: length above 80 behaves as 80
        run_seq(VEC[0][166:87], VEC[0][86:7], 7'd100, 290, "R1 clear");

        // R7: restart from keystream mode (previous run ended in ST_RUN)
        run_seq(VEC[1][166:87], VEC[1][86:7], 7'd6, 40, "R7 restart from run");

        // R7: restart in middle of key absorption
        run_seq(VEC[3][166:87], VEC[3][86:7], 7'd13, 40, "R1 clear");
        run_seq(VEC[1][166:87], VEC[1][86:7], 7'd6, 207, "R7 restart mid key");

        // R7: start during the last preclock cycle wins over entry to keystream
        run_seq(VEC[3][166:87], VEC[3][86:7], 7'd1, 181, "R1 clear");
        run_seq(VEC[2][166:87], VEC[2][86:7], 7'd0, 190, "R7 start on last preclock");

        // R8: asynchronous reset in keystream mode
        #1 rst_n = 1'b0;
        @(negedge clk);
        check5("R8 reset from run", 0, 5'b00000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check5("R8 idle after second reset", 0, 5'b00000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule